// File: doc/BRIEF.md
# Data EEPROM access controller

This block sits between a simple CPU register bus and a small on-chip nonvolatile data memory. Software selects a location through an address register and moves a byte through a data register. A control register holds two command bits. Setting the read command copies the addressed byte into the data register at once. Setting the write command starts a program cycle. The memory itself is modelled as a plain synchronous RAM.

A write lasts a fixed number of cycles of a separate timing oscillator. A counter in that clock domain measures the write time. Its completion is synchronised back to the CPU clock, where it commits the byte and clears the write command bit. Software polls that bit for zero before it starts the next write. While a write is in flight, address changes and new commands are refused. Every accepted access drives a single stall line that freezes the CPU for a fixed number of cycles, and that number depends on the access type.

Top module: `nvm_access_ctrl`

## Requirements
- R1: After reset the address, data and control registers read zero and `stall` is low.
- R2: A bus write to the control register (select 2) with bit 1 set starts a write. Bit 1 reads back as one until the write has finished, and then it clears by itself.
- R3: A write lasts at least WRITE_CYCLES periods of `tclk`. The busy bit clears within a bounded synchronisation delay after that time.
- R4: The byte committed to the array is the data register's value at the cycle the write starts. Later changes to the data register do not alter it.
- R5: An accepted write command raises `stall` for exactly STALL_WR CPU cycles, starting in the cycle after the bus write.
- R6: A bus write to the control register with bit 0 set, while no write is in flight, loads the data register with the addressed byte by the next cycle. Bit 0 reads back as one for that one cycle and as zero afterwards.
- R7: An accepted read command raises `stall` for exactly STALL_RD CPU cycles, starting in the cycle after the bus write.
- R8: While a write is in flight, a read command is ignored. The data register keeps its value, `stall` stays low and control bit 0 stays zero.
- R9: While a write is in flight, bus writes to the address register (select 0) have no effect. A further write command is ignored and raises no stall.
- R10: Register map: select 0 is the address, read back zero-extended above ADDR_W bits. Select 1 is the data register. Select 2 is control (bit 0 read, bit 1 write/busy). Select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| tclk | input | 1 | Timing oscillator clock for the write counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read-back of the selected register |
| stall | output | 1 | CPU stall request, active high |

## Verification
Every location of a 16-byte configuration is written with a distinct arithmetic pattern and then read back. This separates a correct address path from aliasing or stuck address bits, and confirms the stall length of each access type. Each write is timed by polling the busy bit and compared against the bounds that the oscillator period sets. A lockout sequence starts a write and then attempts an address change, a data change, a read and a second write. Reading afterwards tells apart a committed snapshot from a late data value, and a refused address change from an accepted one.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } nvm_sel_e;

  localparam int unsigned CTRL_RD_BIT = 0;
  localparam int unsigned CTRL_WR_BIT = 1;
endpackage

// File: rtl/nvm_sync.sv
module nvm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], d};
  end

  assign q = shift_q[STAGES-1];
endmodule

// File: rtl/nvm_write_timer.sv
module nvm_write_timer #(
  parameter int unsigned WRITE_CYCLES = 26368
) (
  input  logic tclk,
  input  logic trst_n,
  input  logic start_tgl,
  output logic done_tgl
);
  localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

  logic             start_s, start_d_q, start;
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  nvm_sync u_start_sync (.clk(tclk), .rst_n(trst_n), .d(start_tgl), .q(start_s));

  assign start = start_s ^ start_d_q;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (run_q) begin
      if (cnt_q == '0) begin
        run_d  = 1'b0;
        done_d = ~done_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start) begin
      run_d = 1'b1;
      cnt_d = LAST;
    end
  end

  always_ff @(posedge tclk or negedge trst_n) begin
    if (!trst_n) begin
      start_d_q <= 1'b0;
      run_q     <= 1'b0;
      cnt_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      start_d_q <= start_s;
      run_q     <= run_d;
      cnt_q     <= cnt_d;
      done_q    <= done_d;
    end
  end

  assign done_tgl = done_q;

  // R3: the count never leaves its window while running
  a_r3_count_range: assert property (@(posedge tclk) disable iff (!trst_n)
    run_q |-> (cnt_q <= LAST));
  // R3: a new start never arrives while a write is still being timed
  a_r3_no_restart: assert property (@(posedge tclk) disable iff (!trst_n)
    start |-> !run_q);
endmodule

// File: rtl/nvm_stall_gen.sv
module nvm_stall_gen #(
  parameter int unsigned STALL_WR = 2,
  parameter int unsigned STALL_RD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_wr,
  input  logic trig_rd,
  output logic stall_o
);
  localparam int unsigned MAX_ST = (STALL_WR > STALL_RD) ? STALL_WR : STALL_RD;
  localparam int unsigned CW     = $clog2(MAX_ST + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (trig_wr)           cnt_d = CW'(STALL_WR);
    else if (trig_rd)      cnt_d = CW'(STALL_RD);
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign stall_o = (cnt_q != '0);

  // checker state: length of the current stall run and the length it should have
  logic [CW-1:0] run_q, exp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      exp_q <= '0;
    end else if (trig_wr || trig_rd) begin
      run_q <= '0;
      exp_q <= trig_wr ? CW'(STALL_WR) : CW'(STALL_RD);
    end else if (stall_o) begin
      run_q <= run_q + 1'b1;
    end
  end

  // R5 and R7: stall begins in the cycle after the trigger
  a_r5_stall_start: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr || trig_rd) |=> stall_o);
  // R5 and R7: each stall run lasts exactly its access-type length
  a_r7_stall_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_o) |-> (run_q == exp_q));
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/nvm_access_ctrl.sv
module nvm_access_ctrl
  import nvm_pkg::*;
#(
  parameter int unsigned ADDR_W       = 6,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned WRITE_CYCLES = 26368,
  parameter int unsigned STALL_WR     = 2,
  parameter int unsigned STALL_RD     = 4
) (
  input  logic              clk,
  input  logic              tclk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              stall
);
  localparam int unsigned CTRL_PAD = DATA_W - 2;

  logic crst_n, trst_n;
  nvm_sync u_crst (.clk(clk),  .rst_n(rst_n), .d(1'b1), .q(crst_n));
  nvm_sync u_trst (.clk(tclk), .rst_n(rst_n), .d(1'b1), .q(trst_n));

  nvm_sel_e sel;
  assign sel = nvm_sel_e'(bus_sel);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [DATA_W-1:0] pend_q, pend_d;
  logic              busy_q, busy_d;
  logic              rd_bit_q, rd_bit_d;
  logic              req_tgl_q, req_tgl_d;
  logic              done_tgl, done_s, done_d_q, done_pulse;
  logic              hit_ctrl, start_wr, start_rd;
  logic [DATA_W-1:0] arr_rdata;
  logic              arr_we;

  assign hit_ctrl = bus_wr && (sel == SEL_CTRL);
  assign start_wr = hit_ctrl && bus_wdata[CTRL_WR_BIT] && !busy_q;
  assign start_rd = hit_ctrl && bus_wdata[CTRL_RD_BIT] && !bus_wdata[CTRL_WR_BIT] && !busy_q;

  nvm_write_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .tclk(tclk), .trst_n(trst_n), .start_tgl(req_tgl_q), .done_tgl(done_tgl));

  nvm_sync u_done_sync (.clk(clk), .rst_n(crst_n), .d(done_tgl), .q(done_s));
  assign done_pulse = done_s ^ done_d_q;
  assign arr_we     = done_pulse && busy_q;

  nvm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(arr_we), .waddr(addr_q), .wdata(pend_q),
    .raddr(addr_q), .rdata(arr_rdata));

  nvm_stall_gen #(.STALL_WR(STALL_WR), .STALL_RD(STALL_RD)) u_stall (
    .clk(clk), .rst_n(crst_n), .trig_wr(start_wr), .trig_rd(start_rd), .stall_o(stall));

  always_comb begin
    addr_d    = addr_q;
    data_d    = data_q;
    pend_d    = pend_q;
    busy_d    = busy_q;
    rd_bit_d  = start_rd;
    req_tgl_d = req_tgl_q ^ start_wr;
    if (bus_wr && (sel == SEL_ADDR) && !busy_q) addr_d = bus_wdata[ADDR_W-1:0];
    if (bus_wr && (sel == SEL_DATA))            data_d = bus_wdata;
    if (start_rd)                               data_d = arr_rdata;
    if (start_wr) begin
      busy_d = 1'b1;
      pend_d = data_q;
    end else if (done_pulse) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge crst_n) begin
    if (!crst_n) begin
      addr_q    <= '0;
      data_q    <= '0;
      pend_q    <= '0;
      busy_q    <= 1'b0;
      rd_bit_q  <= 1'b0;
      req_tgl_q <= 1'b0;
      done_d_q  <= 1'b0;
    end else begin
      addr_q    <= addr_d;
      data_q    <= data_d;
      pend_q    <= pend_d;
      busy_q    <= busy_d;
      rd_bit_q  <= rd_bit_d;
      req_tgl_q <= req_tgl_d;
      done_d_q  <= done_s;
    end
  end

  always_comb begin
    case (sel)
      SEL_ADDR: bus_rdata = DATA_W'(addr_q);
      SEL_DATA: bus_rdata = data_q;
      SEL_CTRL: bus_rdata = {{CTRL_PAD{1'b0}}, busy_q, rd_bit_q};
      default:  bus_rdata = '0;
    endcase
  end

  // R2: busy holds until the synchronised completion arrives
  a_r2_busy_hold: assert property (@(posedge clk) disable iff (!crst_n)
    (busy_q && !done_pulse) |=> busy_q);
  // R3: completion from the timing domain only arrives during a write
  a_r3_done_while_busy: assert property (@(posedge clk) disable iff (!crst_n)
    done_pulse |-> busy_q);
  // R4: the committed byte is frozen for the whole write
  a_r4_pend_frozen: assert property (@(posedge clk) disable iff (!crst_n)
    busy_q |=> $stable(pend_q));
  // R9: address cannot move while a write is in flight
  a_r9_addr_locked: assert property (@(posedge clk) disable iff (!crst_n)
    busy_q |=> $stable(addr_q));
  // R8: no read is accepted during a write
  a_r8_no_read_busy: assert property (@(posedge clk) disable iff (!crst_n)
    busy_q |=> !rd_bit_q);
  // R6: read bit lasts a single cycle
  a_r6_rd_self_clear: assert property (@(posedge clk) disable iff (!crst_n)
    rd_bit_q |=> !rd_bit_q);
endmodule

// File: tb/nvm_access_ctrl_test.sv
`timescale 1ns/1ps
module nvm_access_ctrl_test;
  localparam int unsigned AW     = 4;
  localparam int unsigned DW     = 8;
  localparam int unsigned WCYC   = 20;
  localparam int unsigned SWR    = 2;
  localparam int unsigned SRD    = 4;
  localparam int unsigned TPER   = 26;
  localparam int unsigned MIN_BUSY = (WCYC * TPER) / 10;
  localparam int unsigned MAX_BUSY = MIN_BUSY + 18;

  logic          clk, tclk, rst_n;
  logic          bus_wr;
  logic [1:0]    bus_sel;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          stall;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  nvm_access_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WRITE_CYCLES(WCYC),
                    .STALL_WR(SWR), .STALL_RD(SRD)) uut (
    .clk(clk), .tclk(tclk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stall(stall));

  initial clk = 1'b0;
  always #5 clk = ~clk;
  initial tclk = 1'b0;
  always #13 tclk = ~tclk;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 5) & 8'hFF);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [DW-1:0] v);
    @(negedge clk);
    bus_sel = s; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_sel = 2'd2;
  endtask

  task automatic peek(input logic [1:0] s, output int v);
    bus_sel = s;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (stall === 1'b1 && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle(output int n);
    int v;
    n = 0;
    peek(2'd2, v);
    while (((v >> 1) & 1) == 1 && n < 500) begin
      n++;
      @(negedge clk);
      peek(2'd2, v);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #500us;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int v, n, busy_n;
    rst_n = 1'b0; bus_wr = 1'b0; bus_sel = 2'd0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    peek(2'd0, v); check(v == 0, "R1 addr", v, 0);
    peek(2'd1, v); check(v == 0, "R1 data", v, 0);
    peek(2'd2, v); check(v == 0, "R1 ctrl", v, 0);
    check(stall == 1'b0, "R1 stall", int'(stall), 0);
    // R10: select 3 reads zero, address zero-extended
    peek(2'd3, v); check(v == 0, "R10 sel3", v, 0);
    bus_write(2'd0, 8'hFF);
    peek(2'd0, v); check(v == 8'h0F, "R10 addr mask", v, 8'h0F);

    // write sweep over every location
    for (int a = 0; a < (1 << AW); a++) begin
      bus_write(2'd0, DW'(a));
      bus_write(2'd1, pat(a));
      bus_write(2'd2, 8'h02);
      peek(2'd2, v); check(((v >> 1) & 1) == 1, "R2 busy set", v, 2);
      count_stall(n); check(n == SWR, "R5 write stall", n, SWR);
      wait_idle(busy_n);
      busy_n += n;
      check(busy_n >= MIN_BUSY && busy_n <= MAX_BUSY, "R3 write duration", busy_n, MIN_BUSY);
      peek(2'd2, v); check(v == 0, "R2 busy cleared", v, 0);
    end

    // read sweep
    for (int a = 0; a < (1 << AW); a++) begin
      bus_write(2'd0, DW'(a));
      bus_write(2'd2, 8'h01);
      peek(2'd2, v); check(v == 1, "R6 read bit set", v, 1);
      peek(2'd1, v); check(v == int'(pat(a)), "R6 read data", v, int'(pat(a)));
      count_stall(n); check(n == SRD, "R7 read stall", n, SRD);
      peek(2'd2, v); check(v == 0, "R6 read bit cleared", v, 0);
    end

    // lockout during a write
    bus_write(2'd0, 8'd5);
    bus_write(2'd1, 8'hA5);
    bus_write(2'd2, 8'h02);
    count_stall(n); check(n == SWR, "R5 write stall", n, SWR);
    bus_write(2'd0, 8'd9);
    peek(2'd0, v); check(v == 5, "R9 addr locked", v, 5);
    bus_write(2'd1, 8'h3C);
    bus_write(2'd2, 8'h01);
    count_stall(n); check(n == 0, "R8 read no stall", n, 0);
    peek(2'd1, v); check(v == 8'h3C, "R8 data kept", v, 8'h3C);
    peek(2'd2, v); check(v == 2, "R8 read bit stays zero", v, 2);
    bus_write(2'd2, 8'h02);
    count_stall(n); check(n == 0, "R9 second write no stall", n, 0);
    wait_idle(n);
    bus_write(2'd0, 8'd5);
    bus_write(2'd2, 8'h01);
    peek(2'd1, v); check(v == 8'hA5, "R4 snapshot committed", v, 8'hA5);
    count_stall(n);
    bus_write(2'd0, 8'd9);
    bus_write(2'd2, 8'h01);
    peek(2'd1, v); check(v == int'(pat(9)), "R9 other location untouched", v, int'(pat(9)));
    count_stall(n);

    finished = 1;
    summary();
    $finish;
  end
endmodule